// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the target end of a four-wire serial port that sits in front of a bank of byte-wide configuration registers. There is one register for each 7-bit address. A controller pulls the active-low select line down and clocks a 16-bit frame into the data-in pin. The frame carries an address, a direction bit and a data byte. A write frame stores the byte in the addressed register. A read frame returns the addressed register on the data-out pin during the second half of the same frame.

The serial clock, select and data-in pins are asynchronous to the block. Each one passes through a two-flop synchronizer clocked by the much faster system clock, and the serial clock edges are detected in that domain. The full register bank is presented as one flat parallel output, so the logic that uses the settings sees them directly. A parameter mask chooses which addresses hold real storage. The other addresses read as zero and ignore writes.

Top module: `scfg_slave`

## Requirements
- R1: A frame is 16 bits, each sampled on a rising serial-clock edge. Bits 0..6 are the address, MSB first. Bit 7 is the direction bit. Bits 8..15 are the data byte, MSB first.
- R2: A direction bit of 1 is a write: the byte is stored at the addressed register and appears on `regs_o[8*a +: 8]`.
- R3: A write takes effect only on the 16th rising edge. After 15 edges the addressed register still holds its old value.
- R4: If select goes high before the 16th rising edge, the frame is dropped and no register changes.
- R5: A direction bit of 0 is a read. After the 8th rising edge, the addressed byte is shifted out MSB first on `sdo_o`, one bit per falling serial edge, so bit 7-k is valid at rising edge 9+k.
- R6: Only addresses whose bit is set in `IMPL_MASK` hold storage; by default these are addresses 0..33. Any other address reads 0x00, ignores writes, and shows 0x00 on `regs_o`.
- R7: `sdo_oe_o` is high only during the data half of a read frame. `sdo_o` is low whenever `sdo_oe_o` is low, which includes while select is high and throughout a write frame.
- R8: After reset all registers are 0x00 and both `sdo_o` and `sdo_oe_o` are low.
- R9: Rising edges after the 16th one in the same select-low period are ignored and cause no further write.
- R10: Registers keep their values across other frames and can be written and read in any order.
- R11: A register change appears on `regs_o` at the third system-clock edge after the 16th rising serial edge: two synchronizer stages, then the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the controller |
| sel_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data) |
| sdo_oe_o | output | 1 | High while `sdo_o` carries read data |
| regs_o | output | 2**ADDR_W*DATA_W | All registers side by side, address a at bits [8a+7:8a] |

## Verification
A serial-clock edge reaches the block's logic two system cycles after the pin changes. The bench therefore changes pins on a falling system clock and holds each serial half-period for eight system cycles, so every result has settled well before it is sampled. For R11 the bench raises the 16th serial edge and then checks `regs_o` at the falling system edges after the second and third rising edges: the old value must still be there after the second, and the new value after the third. Read data is sampled just before each rising serial edge, which is eight cycles after the falling edge that changed it. The state of each register is checked on `regs_o` directly after every frame.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

   localparam int unsigned SCFG_ADDR_W = 7;
   localparam int unsigned SCFG_DATA_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_HEADER = 3'd1,
      PH_WRITE  = 3'd2,
      PH_READ   = 3'd3,
      PH_DONE   = 3'd4
   } scfg_phase_e;

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   input  logic [WIDTH-1:0] rst_val_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("scfg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= rst_val_i;
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   parameter logic [2**ADDR_W-1:0] IMPL_MASK = '1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [ADDR_W-1:0]         wr_addr_i,
   input  logic [DATA_W-1:0]         wr_data_i,
   input  logic [ADDR_W-1:0]         rd_addr_i,
   output logic [DATA_W-1:0]         rd_data_o,
   output logic [2**ADDR_W*DATA_W-1:0] regs_o
);

   localparam int unsigned DEPTH = 2**ADDR_W;

   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_slot
      if (IMPL_MASK[a]) begin : g_impl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot[a] <= '0;
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(a))) begin
               slot[a] <= wr_data_i;
            end
         end
      end else begin : g_absent
         assign slot[a] = '0;
      end
      assign regs_o[a*DATA_W +: DATA_W] = slot[a];
   end

   assign rd_data_o = slot[rd_addr_i];

endmodule

// File: rtl/scfg_frame_rx.sv
module scfg_frame_rx
   import scfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned FRAME_W = ADDR_W + 1 + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s_i,
   input  logic              sel_s_i,
   input  logic              sdi_s_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [CNT_W-1:0]  bit_cnt_o
);

   logic               sck_q;
   logic               sck_rise, sck_fall;
   logic [FRAME_W-1:0] shift_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [DATA_W-1:0]  rd_byte_q;
   logic               sdo_q;
   scfg_phase_e        phase_q;

   assign sck_rise = sck_s_i & ~sck_q;
   assign sck_fall = ~sck_s_i & sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         shift_q   <= '0;
         cnt_q     <= '0;
         rd_byte_q <= '0;
         sdo_q     <= 1'b0;
         phase_q   <= PH_IDLE;
      end else begin
         sck_q <= sck_s_i;
         if (sel_s_i) begin
            cnt_q   <= '0;
            sdo_q   <= 1'b0;
            phase_q <= PH_IDLE;
         end else begin
            if (phase_q == PH_IDLE) begin
               phase_q <= PH_HEADER;
            end
            if (sck_rise && (cnt_q < CNT_W'(FRAME_W))) begin
               shift_q <= {shift_q[FRAME_W-2:0], sdi_s_i};
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(ADDR_W)) begin
                  phase_q <= sdi_s_i ? PH_WRITE : PH_READ;
                  if (!sdi_s_i) begin
                     rd_byte_q <= rd_data_i;
                  end
               end
               if (cnt_q == CNT_W'(FRAME_W-1)) begin
                  phase_q <= PH_DONE;
               end
            end
            if (sck_fall && (phase_q == PH_READ)) begin
               sdo_q     <= rd_byte_q[DATA_W-1];
               rd_byte_q <= {rd_byte_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rd_addr_o = shift_q[ADDR_W-1:0];
   assign wr_en_o   = sck_rise && !sel_s_i && (cnt_q == CNT_W'(FRAME_W-1))
                      && (phase_q == PH_WRITE);
   assign wr_addr_o = shift_q[FRAME_W-2 -: ADDR_W];
   assign wr_data_o = {shift_q[DATA_W-2:0], sdi_s_i};
   assign sdo_oe_o  = (phase_q == PH_READ);
   assign sdo_o     = sdo_q & sdo_oe_o;
   assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/scfg_slave.sv
module scfg_slave #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [2**ADDR_W-1:0] IMPL_MASK =
      128'h0000_0000_0000_0000_0000_0003_FFFF_FFFF,
   localparam int unsigned FRAME_W = ADDR_W + 1 + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1),
   localparam int unsigned BANK_W  = 2**ADDR_W * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              sel_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [BANK_W-1:0] regs_o
);

   if (DATA_W < 2) begin : g_bad_data
      $error("scfg_slave: DATA_W must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("scfg_slave: ADDR_W out of range");
   end

   logic              sck_s, sel_s, sdi_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;
   logic [CNT_W-1:0]  bit_cnt;

   scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_i   ({sck_i, sel_n_i, sdi_i}),
      .rst_val_i (3'b010),
      .sync_o    ({sck_s, sel_s, sdi_s})
   );

   scfg_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s_i   (sck_s),
      .sel_s_i   (sel_s),
      .sdi_s_i   (sdi_s),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .sdo_o     (sdo_o),
      .sdo_oe_o  (sdo_oe_o),
      .bit_cnt_o (bit_cnt)
   );

   scfg_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .regs_o    (regs_o)
   );

endmodule

// File: rtl/scfg_slave_chk.sv
module scfg_slave_chk #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   parameter logic [2**ADDR_W-1:0] IMPL_MASK = '1,
   localparam int unsigned FRAME_W = ADDR_W + 1 + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1),
   localparam int unsigned BANK_W  = 2**ADDR_W * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_s,
   input logic              wr_en,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              sdo_o,
   input logic              sdo_oe_o,
   input logic [BANK_W-1:0] regs_o
);

   logic [BANK_W-1:0] absent_bits;
   for (genvar a = 0; a < 2**ADDR_W; a++) begin : g_mask
      assign absent_bits[a*DATA_W +: DATA_W] = IMPL_MASK[a] ? '0 : '1;
   end

   // R7
   sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> (!sdo_oe_o && !sdo_o));

   // R7
   sdo_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o);

   // R3
   commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bit_cnt == CNT_W'(FRAME_W)));

   // R9
   single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R4
   hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));

   // R6
   absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_o & absent_bits) == '0);

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W));

endmodule

bind scfg_slave scfg_slave_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_s    (sel_s),
   .wr_en    (wr_en),
   .bit_cnt  (bit_cnt),
   .sdo_o    (sdo_o),
   .sdo_oe_o (sdo_oe_o),
   .regs_o   (regs_o)
);

// File: tb/scfg_slave_tb.sv
module scfg_slave_tb_top;

   localparam int HALF = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sck = 1'b0;
   logic          sel_n = 1'b1;
   logic          sdi = 1'b0;
   logic          sdo, sdo_oe;
   logic [1023:0] regs;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] model [128];

   always #10 clk = ~clk;

   scfg_slave dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_i    (sck),
      .sel_n_i  (sel_n),
      .sdi_i    (sdi),
      .sdo_o    (sdo),
      .sdo_oe_o (sdo_oe),
      .regs_o   (regs)
   );

   function automatic bit impl(input int a);
      return a < 34;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Any mismatch between model and regs_o over all 128 slots counts once.
   task automatic check_bank(input string req);
      int bad = -1;
      for (int a = 0; a < 128; a++)
         if (regs[a*8 +: 8] !== model[a] && bad < 0) bad = a;
      if (bad >= 0) check(req, {24'h0, regs[bad*8 +: 8]}, {24'h0, model[bad]});
      else check(req, 0, 0);
   endtask

   // Drive nbits rising edges of a frame; returns read byte; checks R7 per bit.
   task automatic frame(input logic [6:0] a, input bit w, input logic [7:0] d,
                        input int nbits, output logic [7:0] rd, output int oe_err);
      logic [15:0] f = {a, w, d};
      rd = 8'h00;
      oe_err = 0;
      @(negedge clk);
      sel_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 16) ? f[15-i] : ~f[i%16];
         wait_clk(HALF);
         if (sdo_oe !== (!w && i >= 8 && i < 16)) oe_err++;
         if (!sdo_oe && sdo !== 1'b0) oe_err++;
         if (!w && i >= 8 && i < 16) rd[15-i] = sdo;
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      wait_clk(HALF);
      sel_n = 1'b1;
      wait_clk(2*HALF);
      if (sdo !== 1'b0 || sdo_oe !== 1'b0) oe_err++;
      if (w && nbits >= 16 && impl(a)) model[a] = d;
   endtask

   task automatic t_reset;
      check_bank("R8 bank zero after reset");
      check("R8 sdo idle after reset", {30'h0, sdo, sdo_oe}, 0);
   endtask

   task automatic t_write_read;
      logic [7:0] rd; int e;
      frame(7'd3, 1'b1, 8'h5A, 16, rd, e);
      check("R2 write addr3", {24'h0, regs[3*8 +: 8]}, 32'h5A);
      check("R7 write frame keeps sdo idle", e, 0);
      frame(7'd3, 1'b0, 8'h00, 16, rd, e);
      check("R5 read addr3", {24'h0, rd}, 32'h5A);
      check("R7 oe only in read data half", e, 0);
      check_bank("R5 read leaves bank unchanged");
   endtask

   task automatic t_order;
      logic [7:0] rd; int e;
      frame(7'd2, 1'b1, 8'h03, 16, rd, e);
      check("R1 addr MSB first slot2", {24'h0, regs[2*8 +: 8]}, 32'h03);
      check("R1 bit-reversed slot32 untouched", {24'h0, regs[32*8 +: 8]}, 32'h00);
      frame(7'd33, 1'b1, 8'hC3, 16, rd, e);
      frame(7'd0, 1'b1, 8'h81, 16, rd, e);
      frame(7'd33, 1'b0, 8'h00, 16, rd, e);
      check("R10 read addr33 after other writes", {24'h0, rd}, 32'hC3);
      frame(7'd2, 1'b0, 8'h00, 16, rd, e);
      check("R10 addr2 retained", {24'h0, rd}, 32'h03);
      frame(7'd0, 1'b0, 8'h00, 16, rd, e);
      check("R1 data MSB first read addr0", {24'h0, rd}, 32'h81);
      check_bank("R10 bank matches model");
   endtask

   task automatic t_latency;
      logic [15:0] f = {7'd5, 1'b1, 8'hA5};
      @(negedge clk);
      sel_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < 16; i++) begin
         sdi = f[15-i];
         wait_clk(HALF);
         if (i == 15) begin
            check("R3 no change after 15 edges", {24'h0, regs[5*8 +: 8]}, 32'h00);
            sck = 1'b1;
            @(posedge clk); @(posedge clk); @(negedge clk);
            check("R11 unchanged two cycles after edge", {24'h0, regs[5*8 +: 8]}, 32'h00);
            @(posedge clk); @(negedge clk);
            check("R11 written third cycle after edge", {24'h0, regs[5*8 +: 8]}, 32'hA5);
            wait_clk(HALF-3);
         end else begin
            sck = 1'b1;
            wait_clk(HALF);
         end
         sck = 1'b0;
      end
      wait_clk(HALF);
      sel_n = 1'b1;
      wait_clk(2*HALF);
      model[5] = 8'hA5;
   endtask

   task automatic t_abort;
      logic [7:0] rd; int e;
      frame(7'd6, 1'b1, 8'h77, 10, rd, e);
      check_bank("R4 abort after 10 bits");
      frame(7'd6, 1'b1, 8'h77, 15, rd, e);
      check("R4 abort after 15 bits", {24'h0, regs[6*8 +: 8]}, 32'h00);
      frame(7'd3, 1'b0, 8'h00, 12, rd, e);
      check("R4 aborted read leaves sdo idle", e, 0);
   endtask

   task automatic t_unimpl;
      logic [7:0] rd; int e;
      frame(7'd100, 1'b1, 8'hFF, 16, rd, e);
      check("R6 absent slot stays zero", {24'h0, regs[100*8 +: 8]}, 32'h00);
      frame(7'd100, 1'b0, 8'h00, 16, rd, e);
      check("R6 absent read returns zero", {24'h0, rd}, 32'h00);
      check_bank("R6 bank unchanged");
   endtask

   task automatic t_overrun;
      logic [7:0] rd; int e;
      frame(7'd9, 1'b1, 8'h3C, 24, rd, e);
      check("R9 extra edges ignored", {24'h0, regs[9*8 +: 8]}, 32'h3C);
      check_bank("R9 no stray write");
      check("R7 overrun keeps sdo idle", e, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int a = 0; a < 128; a++) model[a] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_write_read();
      t_order();
      t_latency();
      t_abort();
      t_unimpl();
      t_overrun();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule